// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder

This block models the control side of an asynchronous extended-data-out DRAM. A fast internal clock samples the active-low strobes. These are the row strobe, two column strobes (one per byte) and the write and output enables. The block also samples a 10-bit multiplexed address. From the order in which the strobes change, it sorts each cycle into one of five kinds: read, write, row-only refresh, column-first refresh, or hidden refresh.

The block latches the open row and accesses a small register array that stands in for the full cell array. Read data is presented per byte lane. That data stays on the bus after the column strobes return high, and is released only once every strobe is idle.

A refresh tracker keeps an age for the lowest rows. It raises a flag when any of them has gone longer than a set number of clocks without being opened or refreshed. A testbench can watch this flag to confirm that a refresh schedule is being kept.

Top module: `edo_dram_cycle_decoder`

## Requirements
- R1: When the row strobe falls with both column strobes high, `addr` is taken as the open row. A later column strobe fall, sampled with the row strobe low, is a read (kind 1) if `we_n` is high and a write (kind 2) if `we_n` is low. The word accessed is chosen by the low 2 bits of the row and the low 2 bits of the column.
- R2: The column address is the value on `addr` in the clock where the column strobe fall is sampled. A column presented earlier in the row-low period is accepted, and changes to `addr` after the fall have no effect.
- R3: `ucas_n` low selects the byte on bits 15:8 and `lcas_n` low selects the byte on bits 7:0. This holds both for writing from `dq_in` and for driving `dq_oe[1]`/`dq_oe[0]` on a read. Bytes that are not driven read as zero on `dq_out`.
- R4: After a read, the data stays driven while either the row strobe or a column strobe is low. It is released in the clock after one in which all three strobes are sampled high.
- R5: `oe_n` high or `we_n` low forces `dq_oe` to zero.
- R6: A row strobe low period in which no column strobe falls is reported as kind 3 in the clock after the row strobe rises. `cyc_row` then shows the row, and the outputs stay released.
- R7: A row strobe fall with at least one column strobe already low, while no read data is being held, is kind 4. It uses the internal refresh row, keeps the outputs released whatever `oe_n` is, and writes nothing whatever `we_n` is.
- R8: A row strobe fall with a column strobe low while read data is still held is kind 5. It uses the internal refresh row, and the held data keeps being driven.
- R9: The internal refresh row is 10 bits wide and starts at 0. It steps by one after every kind 4 or kind 5 cycle and wraps from 1023 to 0. `cyc_row` reports the value used.
- R10: Several column strobe falls within one row-low period each access the same open row (page mode).
- R11: Rows 0 to `TRK_ROWS-1` each have an age that counts clocks and stops at `WINDOW`. Any row strobe fall that opens or refreshes a row clears that row's age. `stale` is high while any tracked age equals `WINDOW`.
- R12: `kind_stb` pulses for one clock, the clock after the sampled edge that classifies a cycle. `kind` keeps its value until the next classification and resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-byte drive enable (bit 1 upper, bit 0 lower) |
| kind | output | 3 | Last cycle kind: 0 none, 1 read, 2 write, 3 row-only refresh, 4 column-first refresh, 5 hidden refresh |
| kind_stb | output | 1 | One-clock pulse when `kind` is updated |
| cyc_row | output | 10 | Row used by the last classified cycle |
| stale | output | 1 | A tracked row has reached the refresh window |

## Verification
The bench sets a refresh with the column strobes low against one where the column strobes are low and a read is still held. A decoder that ignored the held-data condition would report a column-first refresh and drop the bus in the middle of a hidden refresh. Reads are followed by the column strobes rising first and the row strobe rising later. Releasing on the column strobe alone, as in fast-page behaviour, would cut the data too early. A write issued during a column-first refresh, and a column that changes after the strobe falls, must both leave the array untouched. The refresh row is taken through a full wrap, and the tracker is refreshed for all rows but one to show that `stale` does not clear early.

// File: rtl/edo_dram_cycle_decoder.sv
module edo_dram_cycle_decoder #(
  parameter int ROW_W    = 10,
  parameter int ST_ROW_W = 2,
  parameter int ST_COL_W = 2,
  parameter int TRK_ROWS = 4,
  parameter int WINDOW   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [15:0]      dq_in,
  output logic [15:0]      dq_out,
  output logic [1:0]       dq_oe,
  output logic [2:0]       kind,
  output logic             kind_stb,
  output logic [ROW_W-1:0] cyc_row,
  output logic             stale
);
  localparam int WORDS = 1 << (ST_ROW_W + ST_COL_W);
  localparam int AGE_W = $clog2(WINDOW + 1);
  localparam logic [2:0] K_RD = 3'd1, K_WR = 3'd2, K_RO = 3'd3, K_CBR = 3'd4, K_HID = 3'd5;
  localparam logic [1:0] M_IDLE = 2'd0, M_ACC = 2'd1, M_REF = 2'd2;

  logic ras_q, ucas_q, lcas_q, hold, used;
  logic [1:0] mode, rd_lanes;
  logic [ROW_W-1:0] row_q, rfsh_ctr;
  logic [15:0] rd_data;
  logic [15:0] mem [WORDS];

  wire [1:0] lanes_low = {~ucas_n, ~lcas_n};
  wire [1:0] lane_fall = {ucas_q & ~ucas_n, lcas_q & ~lcas_n};
  wire ras_fall  = ras_q & ~ras_n;
  wire ras_rise  = ~ras_q & ras_n;
  wire all_idle  = ras_n & ucas_n & lcas_n;
  wire rfsh_evt  = ras_fall & (|lanes_low);
  wire acc_evt   = ~ras_n & (mode == M_ACC) & (|lane_fall);
  wire ro_evt    = ras_rise & (mode == M_ACC) & ~used;
  wire [ROW_W-1:0] mark_row = rfsh_evt ? rfsh_ctr : addr;
  wire [ST_ROW_W+ST_COL_W-1:0] idx = {row_q[ST_ROW_W-1:0], addr[ST_COL_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; ucas_q <= 1'b1; lcas_q <= 1'b1;
    end else begin
      ras_q <= ras_n; ucas_q <= ucas_n; lcas_q <= lcas_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; used <= 1'b0; row_q <= '0; rfsh_ctr <= '0;
    end else begin
      if (ras_fall) begin
        if (rfsh_evt) begin
          mode <= M_REF;
          rfsh_ctr <= rfsh_ctr + 1'b1;
        end else begin
          mode <= M_ACC;
          row_q <= addr;
          used <= 1'b0;
        end
      end else if (ras_rise) begin
        mode <= M_IDLE;
      end
      if (acc_evt) used <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (acc_evt && !we_n) begin
      if (lanes_low[1]) mem[idx][15:8] <= dq_in[15:8];
      if (lanes_low[0]) mem[idx][7:0]  <= dq_in[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0; rd_data <= '0; rd_lanes <= '0;
    end else if (all_idle) begin
      hold <= 1'b0;
    end else if (acc_evt) begin
      hold <= we_n;
      if (we_n) begin
        rd_data  <= mem[idx];
        rd_lanes <= lanes_low;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= '0; kind_stb <= 1'b0; cyc_row <= '0;
    end else begin
      kind_stb <= 1'b0;
      if (rfsh_evt) begin
        kind <= hold ? K_HID : K_CBR; kind_stb <= 1'b1; cyc_row <= rfsh_ctr;
      end else if (acc_evt) begin
        kind <= we_n ? K_RD : K_WR; kind_stb <= 1'b1; cyc_row <= row_q;
      end else if (ro_evt) begin
        kind <= K_RO; kind_stb <= 1'b1; cyc_row <= row_q;
      end
    end
  end

  assign dq_oe  = (hold && !oe_n && we_n) ? rd_lanes : 2'b00;
  assign dq_out = rd_data & {{8{dq_oe[1]}}, {8{dq_oe[0]}}};

  logic [TRK_ROWS-1:0] stale_vec;
  for (genvar g = 0; g < TRK_ROWS; g++) begin : g_age
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= '0;
      else if (ras_fall && mark_row == ROW_W'(g)) age <= '0;
      else if (age != AGE_W'(WINDOW)) age <= age + 1'b1;
    end
    assign stale_vec[g] = (age == AGE_W'(WINDOW));
  end
  assign stale = |stale_vec;
endmodule

// File: rtl/edo_dram_cycle_decoder_chk.sv
module edo_dram_cycle_decoder_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             ucas_n,
  input logic             lcas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [1:0]       dq_oe,
  input logic [2:0]       kind,
  input logic             kind_stb,
  input logic             hold,
  input logic [ROW_W-1:0] rfsh_ctr
);
  AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && ucas_n && lcas_n) |=> (dq_oe == 2'b00)); // R4
  AST_CBR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_stb && kind == 3'd4) |-> (dq_oe == 2'b00)); // R7
  AST_HIDDEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_stb && kind == 3'd5) |-> hold); // R8
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_stb && (kind == 3'd4 || kind == 3'd5)) |-> (ROW_W'(rfsh_ctr - $past(rfsh_ctr)) == ROW_W'(1))); // R9
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_stb && kind == 3'd1 && !oe_n && we_n) |-> (dq_oe != 2'b00)); // R3
  AST_STB_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    kind_stb |-> (kind != 3'd0)); // R12
endmodule

bind edo_dram_cycle_decoder edo_dram_cycle_decoder_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .kind(kind), .kind_stb(kind_stb),
  .hold(hold), .rfsh_ctr(rfsh_ctr)
);

// File: tb/edo_dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module edo_dram_cycle_decoder_bench;
  localparam int WIN = 400;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, ucas_n = 1, lcas_n = 1, we_n = 1, oe_n = 0;
  logic [9:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0] dq_oe;
  logic [2:0] kind;
  logic kind_stb, stale;
  logic [9:0] cyc_row;
  int checks = 0, errors = 0, cyc = 0, exp_ctr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edo_dram_cycle_decoder u_edo_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .kind(kind), .kind_stb(kind_stb), .cyc_row(cyc_row), .stale(stale));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mem [int];
  int m_age [4];
  bit m_rp, m_up, m_lp, m_hold, m_used, m_stb;
  int m_mode, m_row, m_ctr, m_rd, m_lanes, m_kind, m_cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem.delete();
      foreach (m_age[i]) m_age[i] = 0;
      m_rp = 1; m_up = 1; m_lp = 1; m_hold = 0; m_used = 0; m_stb = 0;
      m_mode = 0; m_row = 0; m_ctr = 0; m_rd = 0; m_lanes = 0; m_kind = 0; m_cyc = 0;
    end else begin
      bit rf, rr, low, acc, o_hold, o_used; int o_mode, o_row, hit, wi, ln;
      rf = m_rp && !ras_n; rr = !m_rp && ras_n;
      low = !ucas_n || !lcas_n;
      o_hold = m_hold; o_used = m_used; o_mode = m_mode; o_row = m_row;
      acc = !ras_n && o_mode == 1 && ((m_up && !ucas_n) || (m_lp && !lcas_n));
      ln = (!ucas_n ? 2 : 0) + (!lcas_n ? 1 : 0);
      hit = -1; m_stb = 0;
      if (rf && low) begin
        m_kind = o_hold ? 5 : 4; m_stb = 1; m_cyc = m_ctr; hit = m_ctr;
        m_ctr = (m_ctr + 1) % 1024; m_mode = 2;
      end else if (rf) begin
        hit = addr; m_mode = 1; m_row = addr; m_used = 0;
      end else if (rr) begin
        if (o_mode == 1 && !o_used) begin m_kind = 3; m_stb = 1; m_cyc = o_row; end
        m_mode = 0;
      end
      if (acc) begin
        wi = (o_row % 4) * 4 + (addr % 4);
        if (!m_mem.exists(wi)) m_mem[wi] = 0;
        m_stb = 1; m_cyc = o_row; m_used = 1;
        if (we_n) begin m_kind = 1; m_rd = m_mem[wi]; m_lanes = ln; end
        else begin
          m_kind = 2;
          if (ln & 2) m_mem[wi] = (m_mem[wi] & 'h00FF) | (dq_in & 'hFF00);
          if (ln & 1) m_mem[wi] = (m_mem[wi] & 'hFF00) | (dq_in & 'h00FF);
        end
      end
      if (ras_n && ucas_n && lcas_n) m_hold = 0;
      else if (acc) m_hold = we_n;
      for (int i = 0; i < 4; i++)
        if (hit == i) m_age[i] = 0; else if (m_age[i] < WIN) m_age[i]++;
      m_rp = ras_n; m_up = ucas_n; m_lp = lcas_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eoe, eout; bit est;
      eoe = (m_hold && !oe_n && we_n) ? m_lanes : 0;
      eout = m_rd & (((eoe & 2) ? 'hFF00 : 0) | ((eoe & 1) ? 'h00FF : 0));
      est = 0;
      foreach (m_age[i]) if (m_age[i] == WIN) est = 1;
      chk("MODEL R3/R4/R5 dq_oe", 32'(dq_oe), 32'(eoe));
      chk("MODEL R3 dq_out", 32'(dq_out), 32'(eout));
      chk("MODEL R12 kind", 32'(kind), 32'(m_kind));
      chk("MODEL R12 kind_stb", 32'(kind_stb), 32'(m_stb));
      chk("MODEL R9 cyc_row", 32'(cyc_row), 32'(m_cyc));
      chk("MODEL R11 stale", 32'(stale), 32'(est));
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(); ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 0; step(); endtask
  task automatic open_row(input logic [9:0] r); addr = r; ras_n = 0; step(); endtask
  task automatic close_row(); ras_n = 1; step(); endtask
  task automatic cas_acc(input logic [9:0] c, input logic [1:0] ln, input bit wr, input logic [15:0] d);
    addr = c; dq_in = d; we_n = !wr; step();
    {ucas_n, lcas_n} = ~ln; step();
    addr = 10'h3FF ^ c; dq_in = ~d; step();
    {ucas_n, lcas_n} = 2'b11; we_n = 1; step();
  endtask
  task automatic ras_only(input logic [9:0] r);
    open_row(r); step(); close_row(); step();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
      report();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    chk("R12 reset kind", 32'(kind), 0);
    chk("R5 reset dq_oe", 32'(dq_oe), 0);
    chk("R11 reset stale", 32'(stale), 0);
    step();

    // R1 R10 R3 page mode writes then reads
    open_row(10'd5);
    cas_acc(10'd2, 2'b11, 1, 16'hA55A);
    chk("R1 write kind", 32'(kind), 2);
    cas_acc(10'd3, 2'b01, 1, 16'h1234);
    chk("R10 same row", 32'(cyc_row), 5);
    cas_acc(10'd2, 2'b11, 0, 16'h0);
    chk("R1 read kind", 32'(kind), 1);
    chk("R4 EDO hold after CAS high", 32'(dq_out), 32'hA55A);
    chk("R2 later addr change ignored dq_oe", 32'(dq_oe), 3);
    oe_n = 1; #1;
    chk("R5 oe high releases", 32'(dq_oe), 0);
    oe_n = 0; we_n = 0; #1;
    chk("R5 we low releases", 32'(dq_oe), 0);
    we_n = 1; #1;
    cas_acc(10'd3, 2'b01, 0, 16'h0);
    chk("R3 lower lane only", 32'(dq_oe), 1);
    chk("R3 lower byte data", 32'(dq_out), 32'h0034);
    cas_acc(10'd3, 2'b10, 0, 16'h0);
    chk("R3 upper byte unwritten", 32'(dq_out), 32'h0000);
    chk("R3 upper lane only", 32'(dq_oe), 2);
    close_row();
    chk("R4 release after all idle", 32'(dq_oe), 0);

    // R6 row-only refresh
    ras_only(10'd7);
    chk("R6 kind", 32'(kind), 3);
    chk("R6 row", 32'(cyc_row), 7);
    chk("R6 released", 32'(dq_oe), 0);

    // R8 hidden refresh
    open_row(10'd1); cas_acc(10'd0, 2'b11, 1, 16'hC3C3); close_row(); idle();
    open_row(10'd1);
    addr = 10'd0; step();
    ucas_n = 0; lcas_n = 0; step(); step();
    ras_n = 1; step();
    chk("R4 held while CAS low", 32'(dq_out), 32'hC3C3);
    ras_n = 0; step();
    chk("R8 hidden kind", 32'(kind), 5);
    chk("R9 hidden row", 32'(cyc_row), exp_ctr); exp_ctr++;
    chk("R8 still driving", 32'(dq_out), 32'hC3C3);
    step(); ras_n = 1; step(); ucas_n = 1; lcas_n = 1; step(); step();
    chk("R4 released after hidden", 32'(dq_oe), 0);

    // R7 column-first refresh ignores OE and WE
    open_row(10'(exp_ctr % 4)); cas_acc(10'd1, 2'b11, 1, 16'hBEEF); close_row(); idle();
    addr = 10'd1; dq_in = 16'h0000; we_n = 0; oe_n = 0;
    ucas_n = 0; lcas_n = 0; step();
    ras_n = 0; step();
    chk("R7 kind", 32'(kind), 4);
    chk("R7 released", 32'(dq_oe), 0);
    chk("R9 cbr row", 32'(cyc_row), exp_ctr);
    step(); ras_n = 1; step(); idle();
    open_row(10'(exp_ctr % 4)); cas_acc(10'd1, 2'b11, 0, 16'h0);
    chk("R7 no write during refresh", 32'(dq_out), 32'hBEEF);
    close_row(); idle();
    exp_ctr++;

    // R9 full wrap
    for (int k = 0; k < 1030; k++) begin
      ucas_n = 0; lcas_n = 0; step();
      ras_n = 0; step();
      chk("R9 counter sequence", 32'(cyc_row), 32'(exp_ctr % 1024));
      exp_ctr++;
      ras_n = 1; step();
      ucas_n = 1; lcas_n = 1; step();
    end

    // R11 stale tracking
    for (int r = 0; r < 4; r++) ras_only(10'(r));
    chk("R11 fresh rows", 32'(stale), 0);
    repeat (WIN + 5) step();
    chk("R11 window reached", 32'(stale), 1);
    for (int r = 0; r < 3; r++) ras_only(10'(r));
    chk("R11 one row still old", 32'(stale), 1);
    ras_only(10'd3);
    chk("R11 all refreshed", 32'(stale), 0);

    step();
    done = 1;
    report();
  end
endmodule